// File: doc/BRIEF.md
# North Bridge Control Register File

This block holds the control and configuration words of a system north bridge. It has twenty-eight 32-bit registers on one word-wide access port. Each access gives a byte offset. The register index is that offset with its two low bits dropped, and only full 32-bit accesses take effect. Most registers are plain storage that software writes and reads back. A few have defined values after reset, and all others start at zero.

The interrupt enable word cannot be written directly. Software changes it through two alias registers. A write to the set alias ORs the written bits into the enable word, and a write to the clear alias removes them. Both aliases also keep the last value written to them. The enable word and the interrupt status word are read-only. The status word shows the live value of the `isr_in` pins.

When a write to the general configuration word takes its bit 2 from 0 to 1, the block raises `rst_req` for exactly one clock cycle, so that the system can perform a reset. A read returns its data on `rd_data` one clock cycle after the read is issued. `rd_data` keeps that value until the next read.

Top module: `nb_ctrl_regs`

## Requirements
- R1: After reset, the registers read as follows: offset 0x00 = 0x00000C40, 0x04 = 0x00001384, 0x08 = 0x2BFF8010, 0x0C = 0x255E0091, 0x10 = 0x00006140, 0x1C = 0x000001FF, 0x20 = 0x000001FF, 0x68 = 0x00000008, 0x6C = 0x10000000. Every other storage register in 0x00..0x6C reads zero, and `rd_data` itself is zero.
- R2: A word write to a plain storage offset replaces the whole word. A word read (`acc_vld`=1, `acc_wr`=0, `acc_word`=1) puts the register value on `rd_data` at the first clock edge after the read, and `rd_data` holds that value until the next read.
- R3: A word write to offset 0x30 stores the data in 0x30 and ORs it into the enable word at 0x38.
- R4: A word write to offset 0x34 stores the data in 0x34 and clears from the enable word at 0x38 every bit that is 1 in the data.
- R5: Writes to 0x38 and 0x3C change nothing. A read of 0x3C returns the value of `isr_in` in the cycle of the read.
- R6: A word write to 0x04 whose data has bit 2 = 1, while the stored bit 2 is 0, makes `rst_req` high for exactly the one cycle after that write's clock edge. `rst_req` stays low in every other case, including when the stored bit 2 is already 1.
- R7: Writes to offsets 0x70 and above are ignored, and reads there return zero.
- R8: An access with `acc_word`=0 does not change any register, does not raise `rst_req`, and reads as zero.
- R9: Address bits [1:0] are ignored. Offsets 4k to 4k+3 all reach register k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_vld | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = full 32-bit access; other sizes are ignored |
| acc_addr | input | 8 | Byte offset |
| acc_wdata | input | 32 | Write data |
| isr_in | input | 32 | Live interrupt status shown at offset 0x3C |
| rd_data | output | 32 | Read data, one cycle after the read |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Two things happen on the same clock edge when the general configuration word is written: the new word is stored, and the old bit 2 is compared with the new one to decide on `rst_req`. The bench first writes 0x04 with bit 2 clear and then with bit 2 set. It checks the pulse in the cycle after the second write, and reads the stored word back to confirm it is the new value. A third write that keeps bit 2 set must produce no pulse. A byte-sized write carrying bit 2 must produce no pulse either. The bench also sends set and clear alias writes back to back, and checks each read of the enable word against a running OR/AND-NOT model.

// File: rtl/nb_pkg.sv
package nb_pkg;

  // Register indices whose behaviour differs from plain storage
  localparam int IDX_GEN     = 1;   // general configuration, holds reset trigger bit
  localparam int IDX_SET     = 12;  // enable set alias
  localparam int IDX_CLR     = 13;  // enable clear alias
  localparam int IDX_EN      = 14;  // read-only interrupt enable
  localparam int IDX_ISR     = 15;  // read-only interrupt status
  localparam int GEN_RST_BIT = 2;

  // Value loaded into a register index at reset
  function automatic logic [31:0] nb_reset_value(input int idx);
    logic [31:0] v;
    case (idx)
      0:       v = 32'h0000_0C40;
      1:       v = 32'h0000_1384;
      2:       v = 32'h2BFF_8010;
      3:       v = 32'h255E_0091;
      4:       v = 32'h0000_6140;
      7:       v = 32'h0000_01FF;
      8:       v = 32'h0000_01FF;
      26:      v = 32'h0000_0008;
      27:      v = 32'h1000_0000;
      default: v = 32'h0000_0000;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/nb_rst_sync.sv
module nb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/nb_decode.sv
module nb_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 28
) (
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic              acc_word,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [NUM_REGS-1:0] wr_sel,
  output logic              rd_hit,
  output logic [ADDR_W-3:0] rd_idx
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic             wr_ok;

  always_comb begin
    idx      = acc_addr[ADDR_W-1:2];
    in_range = (int'(idx) < NUM_REGS);
    wr_ok    = acc_vld && acc_wr && acc_word && in_range;
    rd_hit   = acc_word && in_range;
    rd_idx   = idx;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign wr_sel[i] = wr_ok && (idx == IDX_W'(i));
  end

endmodule

// File: rtl/nb_store.sv
module nb_store
  import nb_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 28
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:0]              wr_sel,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  store_q
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == IDX_EN || i == IDX_ISR) begin : g_none
      // Read-only words keep no storage here
      assign store_q[i] = '0;
    end else begin : g_ff
      localparam logic [DATA_W-1:0] RSTV = DATA_W'(nb_reset_value(i));
      logic [DATA_W-1:0] word_d;
      logic [DATA_W-1:0] word_q;
      logic              word_ce;

      always_comb begin
        word_ce = wr_sel[i];
        word_d  = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word_q <= RSTV;
        end else if (word_ce) begin
          word_q <= word_d;
        end
      end

      assign store_q[i] = word_q;
    end
  end

endmodule

// File: rtl/nb_irq_en.sv
module nb_irq_en #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wr,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q
);

  logic [DATA_W-1:0] en_d;
  logic              en_ce;

  always_comb begin
    en_ce = set_wr || clr_wr;
    en_d  = en_q;
    if (set_wr) begin
      en_d = en_q | wdata;
    end else if (clr_wr) begin
      en_d = en_q & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

endmodule

// File: rtl/nb_rst_pulse.sv
module nb_rst_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse_q
);

  logic pulse_d;

  always_comb begin
    pulse_d = trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

endmodule

// File: rtl/nb_ctrl_regs.sv
module nb_ctrl_regs
  import nb_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic              acc_word,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [DATA_W-1:0] isr_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_req
);

  localparam int IDX_W = ADDR_W - 2;

  logic                            rst_sync_n;
  logic [NUM_REGS-1:0]             wr_sel;
  logic                            rd_hit;
  logic [IDX_W-1:0]                rd_idx;
  logic [NUM_REGS-1:0][DATA_W-1:0] store_q;
  logic [DATA_W-1:0]               irq_en_q;
  logic                            gen_trig;
  logic [DATA_W-1:0]               rd_d;
  logic [DATA_W-1:0]               rd_q;
  logic                            rd_ce;

  nb_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nb_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
    .acc_vld  (acc_vld),
    .acc_wr   (acc_wr),
    .acc_word (acc_word),
    .acc_addr (acc_addr),
    .wr_sel   (wr_sel),
    .rd_hit   (rd_hit),
    .rd_idx   (rd_idx)
  );

  nb_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_sel  (wr_sel),
    .wdata   (acc_wdata),
    .store_q (store_q)
  );

  nb_irq_en #(.DATA_W(DATA_W)) u_irq_en (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_wr (wr_sel[IDX_SET]),
    .clr_wr (wr_sel[IDX_CLR]),
    .wdata  (acc_wdata),
    .en_q   (irq_en_q)
  );

  // Rising edge of the trigger bit: old stored value against incoming data
  always_comb begin
    gen_trig = wr_sel[IDX_GEN] && !store_q[IDX_GEN][GEN_RST_BIT]
               && acc_wdata[GEN_RST_BIT];
  end

  nb_rst_pulse u_rst_pulse (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .trig    (gen_trig),
    .pulse_q (rst_req)
  );

  // Read path
  always_comb begin
    rd_ce = acc_vld && !acc_wr;
    rd_d  = '0;
    if (rd_hit) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (rd_idx == IDX_W'(i)) begin
          if (i == IDX_EN) begin
            rd_d = irq_en_q;
          end else if (i == IDX_ISR) begin
            rd_d = isr_in;
          end else begin
            rd_d = store_q[i];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q <= '0;
    end else if (rd_ce) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/nb_ctrl_regs_chk.sv
module nb_ctrl_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_vld,
  input logic              acc_wr,
  input logic              acc_word,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic [DATA_W-1:0] en_q,
  input logic [DATA_W-1:0] rd_data,
  input logic              rst_req
);

  logic set_w;
  logic clr_w;
  logic gen_w;
  logic hi_rd;

  always_comb begin
    set_w = acc_vld && acc_wr && acc_word && (acc_addr[ADDR_W-1:2] == 6'd12);
    clr_w = acc_vld && acc_wr && acc_word && (acc_addr[ADDR_W-1:2] == 6'd13);
    gen_w = acc_vld && acc_wr && acc_word && (acc_addr[ADDR_W-1:2] == 6'd1);
    hi_rd = acc_vld && !acc_wr && (acc_addr >= 8'h70);
  end

  // R6
  rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R6
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(gen_w) && $past(acc_wdata[2]));

  // R3
  set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_w |=> ((en_q & $past(acc_wdata)) == $past(acc_wdata)));

  // R4
  clr_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> ((en_q & $past(acc_wdata)) == '0));

  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_w || clr_w) |=> $stable(en_q));

  // R7
  high_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd |=> (rd_data == '0));

endmodule

bind nb_ctrl_regs nb_ctrl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .acc_vld   (acc_vld),
  .acc_wr    (acc_wr),
  .acc_word  (acc_word),
  .acc_addr  (acc_addr),
  .acc_wdata (acc_wdata),
  .en_q      (irq_en_q),
  .rd_data   (rd_data),
  .rst_req   (rst_req)
);

// File: tb/test_nb_ctrl_regs.sv
`timescale 1ns/1ps
module test_nb_ctrl_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_vld = 1'b0;
  logic        acc_wr = 1'b0;
  logic        acc_word = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] isr_in = '0;
  logic [31:0] rd_data;
  logic        rst_req;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mdl [0:27];
  logic [31:0] en_m;

  always #10 clk = ~clk;

  nb_ctrl_regs i_nb_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
    .acc_word(acc_word), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .isr_in(isr_in), .rd_data(rd_data), .rst_req(rst_req)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a, input bit w);
    int k;
    k = int'(a[7:2]);
    if (!w || a >= 8'h70) return 32'h0;
    if (k == 14) return en_m;
    if (k == 15) return isr_in;
    return mdl[k];
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit w);
    bit exp_p;
    int k;
    k = int'(a[7:2]);
    @(negedge clk);
    acc_vld = 1'b1; acc_wr = 1'b1; acc_word = w; acc_addr = a; acc_wdata = d;
    exp_p = w && (k == 1) && !mdl[1][2] && d[2];
    if (w && a < 8'h70) begin
      if (k == 12) begin mdl[12] = d; en_m = en_m | d; end
      else if (k == 13) begin mdl[13] = d; en_m = en_m & ~d; end
      else if (k != 14 && k != 15) mdl[k] = d;
    end
    @(negedge clk);
    acc_vld = 1'b0;
    chk(rst_req == exp_p, "R6 pulse", {31'b0, rst_req}, {31'b0, exp_p});
  endtask

  task automatic rd(input logic [7:0] a, input bit w, input string req);
    logic [31:0] e;
    @(negedge clk);
    acc_vld = 1'b1; acc_wr = 1'b0; acc_word = w; acc_addr = a;
    e = exp_rd(a, w);
    @(negedge clk);
    acc_vld = 1'b0;
    chk(rd_data == e, req, rd_data, e);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 28; i++) mdl[i] = 32'h0;
    mdl[0] = 32'h0000_0C40; mdl[1] = 32'h0000_1384; mdl[2] = 32'h2BFF_8010;
    mdl[3] = 32'h255E_0091; mdl[4] = 32'h0000_6140; mdl[7] = 32'h0000_01FF;
    mdl[8] = 32'h0000_01FF; mdl[26] = 32'h0000_0008; mdl[27] = 32'h1000_0000;
    en_m = 32'h0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state of the outputs
    chk(rd_data == 32'h0, "R1 rd_data reset", rd_data, 32'h0);
    chk(rst_req == 1'b0, "R6 rst_req reset", {31'b0, rst_req}, 32'h0);

    // R1 / R7: sweep every word offset after reset
    isr_in = 32'hC0DE_0001;
    for (int i = 0; i < 64; i++) rd(8'(i * 4), 1'b1, "R1 R7 reset sweep");

    // R2 R3 R4 R5 R7: write every word offset, then read all back
    for (int i = 0; i < 64; i++)
      wr(8'(i * 4), (32'h1357_9BDF * 32'(i + 1)) ^ 32'hA5A5_0F0F, 1'b1);
    for (int i = 0; i < 64; i++) rd(8'(i * 4), 1'b1, "R2 R5 R7 write sweep");

    // R3 R4: set and clear aliases back to back
    wr(8'h34, 32'hFFFF_FFFF, 1'b1);
    rd(8'h38, 1'b1, "R4 clear all");
    wr(8'h30, 32'h0000_0F0F, 1'b1);
    wr(8'h30, 32'h0000_3000, 1'b1);
    rd(8'h38, 1'b1, "R3 set accumulate");
    rd(8'h30, 1'b1, "R3 set alias stored");
    wr(8'h34, 32'h0000_0101, 1'b1);
    rd(8'h38, 1'b1, "R4 clear bits");
    rd(8'h34, 1'b1, "R4 clear alias stored");
    wr(8'h38, 32'hFFFF_FFFF, 1'b1);
    rd(8'h38, 1'b1, "R5 enable write ignored");

    // R5: status follows isr_in, writes ignored
    for (int i = 0; i < 8; i++) begin
      isr_in = 32'h0101_0101 << i;
      wr(8'h3C, 32'hDEAD_BEEF, 1'b1);
      rd(8'h3C, 1'b1, "R5 status read");
    end

    // R6: bit 2 rising edge only
    wr(8'h04, 32'h0000_0000, 1'b1);
    wr(8'h04, 32'h0000_0004, 1'b1);
    rd(8'h04, 1'b1, "R6 stored with pulse");
    wr(8'h04, 32'h0000_0006, 1'b1);
    wr(8'h04, 32'h0000_0000, 1'b1);
    wr(8'h04, 32'h0000_0004, 1'b0);
    rd(8'h04, 1'b1, "R8 byte write ignored");
    wr(8'h04, 32'hFFFF_FFFF, 1'b1);

    // R8: non-word accesses
    wr(8'h40, 32'h1111_2222, 1'b1);
    wr(8'h40, 32'h3333_4444, 1'b0);
    rd(8'h40, 1'b1, "R8 word readback");
    rd(8'h40, 1'b0, "R8 byte read zero");

    // R9: low address bits ignored
    for (int b = 1; b < 4; b++) begin
      wr(8'(8'h44 + b), 32'h00AB_0000 + 32'(b), 1'b1);
      rd(8'h44, 1'b1, "R9 alias write");
      rd(8'(8'h44 + 4 - b), 1'b1, "R9 alias read");
    end

    // R7: high offsets with low bits set
    wr(8'h73, 32'hFFFF_FFFF, 1'b1);
    rd(8'h73, 1'b1, "R7 high offset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule